// File: doc/BRIEF.md
# Three-State Trigger Mask Matcher

This block takes one reference event at a time. For each source the event carries the primitive IDs found in three neighbouring time slots, and each slot has an in-time flag. The block folds the slots of each source into one merged ID. It then tests the merged IDs of all sources against a programmable table of trigger masks, and all masks are tested at once. Every bit of a mask, for every source, is either required set, required clear (a veto) or ignored. A mask that matches passes through its own downscaler, which lets only a chosen fraction of its matches fire.

The result is registered one clock edge after the event. It holds a trigger strobe, a bitmap that names every mask that fired, and the merged IDs of that event. Software can use the merged IDs to work out which primitives caused the trigger. The mask table is loaded through a simple write port that selects a mask, a source and a field.

Top module: `trig_mask_matcher`

## Requirements
- R1: The merged ID of source s is the bitwise OR of the IDs of its three slots, and only slots whose in-time flag is 1 contribute. Slot k of source s occupies `ev_ids[(s*3+k)*8 +: 8]` and `ev_intime[s*3+k]`. The merged IDs appear on `merged_ids[s*8 +: 8]` one edge after an accepted event, and they hold their value while `ev_valid` is 0.
- R2: Each mask stores a care vector and a value vector for each source. A care bit of 1 requires the merged ID bit to equal the value bit. A value of 1 means the bit must be set, and a value of 0 is a veto on that bit.
- R3: A merged ID bit whose care bit is 0 is ignored and has no effect on the match.
- R4: A mask matches only when every source satisfies its care and value vectors.
- R5: All masks (16 by default) are evaluated in the same cycle. `fire_map[m]` reports mask m for the event presented one edge earlier, and several bits can be set together.
- R6: A mask whose enable is 0 never fires. While it is disabled, its downscale counter does not advance. After it is enabled again, the count resumes where it stopped.
- R7: With a downscale factor N of 2 or more, a mask fires on its first match and then on every Nth match after it. Factors 0 and 1 both let every match fire.
- R8: `trig_strobe` is 1 exactly when `fire_map` is nonzero. A cycle with `ev_valid` at 0 yields `trig_strobe` 0 and `fire_map` 0.
- R9: Reset clears all care and value vectors, disables every mask, sets every factor to 0 and clears all outputs.
- R10: Configuration writes take effect when `cfg_we` is 1. The `cfg_field` codes are 0 for the care vector, 1 for the value vector, 2 for the downscale factor and 3 for the enable (`cfg_data[0]`). Writing the factor of a mask restarts its count, so its next match fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 4 | Mask index written |
| cfg_src | input | 2 | Source index for care/value writes |
| cfg_field | input | 2 | Field code: 0 care, 1 value, 2 factor, 3 enable |
| cfg_data | input | 8 | Write data |
| ev_valid | input | 1 | Reference event present this cycle |
| ev_ids | input | 96 | Slot IDs, slot k of source s at bits (s*3+k)*8 |
| ev_intime | input | 12 | In-time flag per slot, index s*3+k |
| trig_strobe | output | 1 | At least one mask fired |
| fire_map | output | 16 | Masks that fired on the last event |
| merged_ids | output | 32 | Merged ID per source of the last event |

## Verification
The checker tests a set of relations on every cycle. The strobe must agree with the bitmap. An idle cycle must produce no firing and must leave the merged IDs unchanged. A mask that was disabled in the previous cycle must never appear in the bitmap. Reset must clear the outputs. The bench scenarios cover everything that depends on values: the in-time gating of the merge, veto and don't-care bits, the match across all sources, simultaneous hits, and the exact downscale sequences. These include a pause while a mask is disabled and a counter restart after the factor is rewritten.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;
    localparam int ID_W   = 8;
    localparam int DS_W   = 8;
    localparam int SLOTS  = 3;
    localparam int CFG_W  = (ID_W > DS_W) ? ID_W : DS_W;

    typedef enum logic [1:0] {
        FLD_CARE   = 2'd0,
        FLD_VALUE  = 2'd1,
        FLD_FACTOR = 2'd2,
        FLD_ENABLE = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic            en;
        logic [DS_W-1:0] factor;
    } mask_ctrl_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tm_src_merge.sv
module tm_src_merge
    import trig_match_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC*SLOTS*ID_W-1:0] ids,
    input  logic [NUM_SRC*SLOTS-1:0]      intime,
    output logic [NUM_SRC*ID_W-1:0]       gid
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_comb begin
            gid[s*ID_W +: ID_W] = '0;
            for (int k = 0; k < SLOTS; k++) begin
                if (intime[s*SLOTS+k])
                    gid[s*ID_W +: ID_W] = gid[s*ID_W +: ID_W] | ids[(s*SLOTS+k)*ID_W +: ID_W];
            end
        end
    end
endmodule

// File: rtl/tm_mask_eval.sv
module tm_mask_eval
    import trig_match_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC*ID_W-1:0] gid,
    input  logic [NUM_SRC*ID_W-1:0] care,
    input  logic [NUM_SRC*ID_W-1:0] value,
    input  logic                    en,
    output logic                    hit
);
    always_comb begin
        hit = en;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (((gid[s*ID_W +: ID_W] ^ value[s*ID_W +: ID_W]) & care[s*ID_W +: ID_W]) != '0)
                hit = 1'b0;
        end
    end
endmodule

// File: rtl/tm_downscale.sv
module tm_downscale
    import trig_match_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [DS_W-1:0] factor,
    input  logic            hit,
    output logic            pass
);
    logic [DS_W-1:0] cnt;
    logic [DS_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + (DS_W+1)'(1);
    assign pass    = hit && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (hit) begin
            if (cnt_inc >= {1'b0, factor})
                cnt <= '0;
            else
                cnt <= cnt_inc[DS_W-1:0];
        end
    end
endmodule

// File: rtl/trig_mask_matcher.sv
module trig_mask_matcher
    import trig_match_pkg::*;
#(
    parameter int NUM_SRC  = 4,
    parameter int NUM_MASK = 16,
    localparam int MI_W    = idx_w(NUM_MASK),
    localparam int SI_W    = idx_w(NUM_SRC)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [MI_W-1:0]               cfg_mask,
    input  logic [SI_W-1:0]               cfg_src,
    input  logic [1:0]                    cfg_field,
    input  logic [CFG_W-1:0]              cfg_data,
    input  logic                          ev_valid,
    input  logic [NUM_SRC*SLOTS*ID_W-1:0] ev_ids,
    input  logic [NUM_SRC*SLOTS-1:0]      ev_intime,
    output logic                          trig_strobe,
    output logic [NUM_MASK-1:0]           fire_map,
    output logic [NUM_SRC*ID_W-1:0]       merged_ids
);
    logic [NUM_SRC*ID_W-1:0] care_q  [NUM_MASK];
    logic [NUM_SRC*ID_W-1:0] value_q [NUM_MASK];
    mask_ctrl_t              ctrl_q  [NUM_MASK];
    logic [NUM_MASK-1:0]     en_vec;
    logic [NUM_MASK-1:0]     hit_vec;
    logic [NUM_MASK-1:0]     pass_vec;
    logic [NUM_SRC*ID_W-1:0] gid;
    logic                    cfg_ok;

    assign cfg_ok = cfg_we && (int'(cfg_mask) < NUM_MASK) && (int'(cfg_src) < NUM_SRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < NUM_MASK; m++) begin
                care_q[m]  <= '0;
                value_q[m] <= '0;
                ctrl_q[m]  <= '0;
            end
        end else if (cfg_ok) begin
            case (cfg_field)
                FLD_CARE:   care_q[cfg_mask][int'(cfg_src)*ID_W +: ID_W]  <= cfg_data[ID_W-1:0];
                FLD_VALUE:  value_q[cfg_mask][int'(cfg_src)*ID_W +: ID_W] <= cfg_data[ID_W-1:0];
                FLD_FACTOR: ctrl_q[cfg_mask].factor <= cfg_data[DS_W-1:0];
                default:    ctrl_q[cfg_mask].en     <= cfg_data[0];
            endcase
        end
    end

    tm_src_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .ids    (ev_ids),
        .intime (ev_intime),
        .gid    (gid)
    );

    for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
        logic eval_hit;
        logic restart;

        assign en_vec[m] = ctrl_q[m].en;
        assign restart   = cfg_ok && (cfg_field == FLD_FACTOR) && (int'(cfg_mask) == m);
        assign hit_vec[m] = ev_valid && eval_hit;

        tm_mask_eval #(.NUM_SRC(NUM_SRC)) u_eval (
            .gid   (gid),
            .care  (care_q[m]),
            .value (value_q[m]),
            .en    (en_vec[m]),
            .hit   (eval_hit)
        );

        tm_downscale u_ds (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .factor  (ctrl_q[m].factor),
            .hit     (hit_vec[m]),
            .pass    (pass_vec[m])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_strobe <= 1'b0;
            fire_map    <= '0;
            merged_ids  <= '0;
        end else begin
            trig_strobe <= |pass_vec;
            fire_map    <= pass_vec;
            if (ev_valid)
                merged_ids <= gid;
        end
    end
endmodule

// File: rtl/tm_matcher_chk.sv
module tm_matcher_chk
    import trig_match_pkg::*;
#(
    parameter int NUM_SRC  = 4,
    parameter int NUM_MASK = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ev_valid,
    input logic                    trig_strobe,
    input logic [NUM_MASK-1:0]     fire_map,
    input logic [NUM_SRC*ID_W-1:0] merged_ids,
    input logic [NUM_MASK-1:0]     mask_en
);
    // R8
    strobe_map_chk: assert property (@(posedge clk) disable iff (rst)
        trig_strobe == (fire_map != '0));

    // R8
    idle_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> (fire_map == '0) && !trig_strobe);

    // R1
    ids_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> $stable(merged_ids));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fire_map & ~$past(mask_en)) == '0);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (fire_map == '0) && !trig_strobe && (merged_ids == '0));
endmodule

bind trig_mask_matcher tm_matcher_chk #(.NUM_SRC(NUM_SRC), .NUM_MASK(NUM_MASK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_valid    (ev_valid),
    .trig_strobe (trig_strobe),
    .fire_map    (fire_map),
    .merged_ids  (merged_ids),
    .mask_en     (en_vec)
);

// File: tb/tb_trig_mask_matcher.sv
`timescale 1ns/1ps
module tb_trig_mask_matcher;
    localparam int NS = 4;
    localparam int NM = 16;
    localparam int IW = 8;
    localparam int VW = NS*3*IW + NS*3 + NM + NS*IW;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cfg_we = 1'b0;
    logic [3:0]           cfg_mask = '0;
    logic [1:0]           cfg_src = '0;
    logic [1:0]           cfg_field = '0;
    logic [7:0]           cfg_data = '0;
    logic                 ev_valid = 1'b0;
    logic [NS*3*IW-1:0]   ev_ids = '0;
    logic [NS*3-1:0]      ev_intime = '0;
    logic                 trig_strobe;
    logic [NM-1:0]        fire_map;
    logic [NS*IW-1:0]     merged_ids;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_mask_matcher dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_src(cfg_src),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .ev_valid(ev_valid), .ev_ids(ev_ids),
        .ev_intime(ev_intime), .trig_strobe(trig_strobe), .fire_map(fire_map),
        .merged_ids(merged_ids)
    );

    // {ids, intime, expected fire_map, expected merged_ids}
    localparam logic [VW-1:0] VECS [7] = '{
        {96'h00000000_00000000_00000000, 12'hFFF, 16'h0000, 32'h00000000},
        {96'h00000000_00000000_00000100, 12'hFFF, 16'h0003, 32'h00000001},
        {96'h00000000_00000000_02010000, 12'hFFF, 16'h0001, 32'h00000201},
        {96'h00000000_00000000_00000001, 12'hFFE, 16'h0000, 32'h00000000},
        {96'h00000000_0A500000_00000081, 12'hFFF, 16'h0007, 32'h005A0081},
        {96'h00000000_015A0002_00FE0000, 12'hF7F, 16'h0004, 32'h005A02FE},
        {96'hFFFFFF00_00000000_00000001, 12'hFFF, 16'h0003, 32'hFF000001}
    };
    localparam string VTAG [7] = '{"R2", "R2", "R2", "R1", "R5", "R3", "R4"};

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int m, input int s, input int f, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mask = 4'(m); cfg_src = 2'(s); cfg_field = 2'(f); cfg_data = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [NS*3*IW-1:0] ids, input logic [NS*3-1:0] it);
        @(negedge clk);
        ev_valid = 1'b1; ev_ids = ids; ev_intime = it;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic expect_map(input string tag, input logic [NM-1:0] exp);
        chk(fire_map == exp && trig_strobe == (exp != '0), tag,
            {trig_strobe, fire_map}, {(exp != '0), exp});
    endtask

    task automatic run_pattern(input string tag, input int n, input logic [15:0] pat, input logic [NM-1:0] bitv);
        for (int i = 0; i < n; i++) begin
            send('0, '1);
            expect_map(tag, pat[i] ? bitv : '0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fire_map == '0 && !trig_strobe && merged_ids == '0, "R9 reset outputs",
            {fire_map, merged_ids}, 64'd0);

        // R10 programming: field 0 care, 1 value, 3 enable
        cfg(0, 0, 0, 8'h01); cfg(0, 0, 1, 8'h01); cfg(0, 0, 3, 1);
        cfg(1, 0, 0, 8'h01); cfg(1, 0, 1, 8'h01); cfg(1, 1, 0, 8'h02); cfg(1, 1, 1, 8'h00); cfg(1, 0, 3, 1);
        cfg(2, 2, 0, 8'hFF); cfg(2, 2, 1, 8'h5A); cfg(2, 0, 3, 1);

        for (int v = 0; v < 7; v++) begin
            logic [VW-1:0] e;
            e = VECS[v];
            send(e[VW-1 -: 96], e[NM+NS*IW +: 12]);
            expect_map(VTAG[v], e[NS*IW +: NM]);
            chk(merged_ids == e[NS*IW-1:0], "R1 merged ids", merged_ids, e[NS*IW-1:0]);
        end

        // R7 factor 3 on always-matching mask 5
        cfg(5, 0, 2, 3); cfg(5, 0, 3, 1);
        run_pattern("R7 factor3", 7, 16'b1001001, 16'h0020);
        // R6 disabled: no fire, count frozen (count is 1 here)
        cfg(5, 0, 3, 0);
        run_pattern("R6 disabled", 5, 16'b0, 16'h0020);
        cfg(5, 0, 3, 1);
        run_pattern("R6 resume", 3, 16'b100, 16'h0020);
        // R7 factors 1 and 0
        cfg(5, 0, 2, 1);
        run_pattern("R7 factor1", 3, 16'b111, 16'h0020);
        cfg(5, 0, 2, 0);
        run_pattern("R7 factor0", 3, 16'b111, 16'h0020);
        // R10 factor rewrite restarts count
        cfg(5, 0, 2, 4);
        run_pattern("R10 before rewrite", 2, 16'b01, 16'h0020);
        cfg(5, 0, 2, 4);
        run_pattern("R10 after rewrite", 1, 16'b1, 16'h0020);
        // R5 highest mask fires together with mask 5
        cfg(5, 0, 2, 0); cfg(15, 0, 3, 1);
        send('0, '1);
        expect_map("R5 two masks", 16'h8020);

        // R8 idle cycle
        @(negedge clk);
        expect_map("R8 idle", 16'h0000);

        // R9 reset disables all masks
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        send(96'h00000000_00000000_00000001, '1);
        expect_map("R9 masks disabled", 16'h0000);
        chk(merged_ids == 32'h00000001, "R1 after reset", merged_ids, 32'h00000001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule